// File: doc/BRIEF.md
# ADC Conversion Sequencer

This controller drives a successive-approximation converter from the digital side. Software programs a control word, a list of up to four channel slots and a pair of window thresholds through a simple word-addressed register port. An external trigger then starts a conversion run. For each conversion the block presents a channel number and a one-cycle start pulse. It times the conversion in converter-clock cycles according to the chosen resolution, and it captures the digital sample into a data register.

Three modes set how many conversions a trigger launches. In single mode a trigger converts slot 0 once. In scan mode a trigger converts the whole list in order. In discontinuous mode each trigger converts a subgroup of 1 to 8 conversions, and the next trigger resumes where the previous subgroup stopped. Completion, overrun and window-violation flags are kept in a status word. Each flag reaches the interrupt line only through its own enable.

Register word addresses: 0 control, 1 sequence, 2 high threshold, 3 low threshold, 4 data, 5 status. The sequence word holds slot k at bits [5k+4:5k] and the list length minus one at bits [25:24]. The status word holds completion at bit 0, overrun at bit 1 and window violation at bit 2.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word resets to zero. Bits 31:27 and 21:16 always read zero and ignore writes. Every other bit reads back what was written.
- R2: Control bits 25:24 select the conversion length: code 0 takes 15 cycles, 1 takes 13, 2 takes 11 and 3 takes 9. The completion flag becomes visible exactly that many cycles after the cycle in which `conv_start` is high.
- R3: With scan (bit 8) and discontinuous (bit 11) both clear, one trigger gives exactly one start pulse, with `conv_ch` equal to slot 0.
- R4: With scan set and discontinuous clear, one trigger converts slots 0 to the list length in order. Each new start follows the previous capture directly.
- R5: With discontinuous set, each trigger converts bits 15:13 plus one channels. The slot pointer advances across triggers and wraps from the last listed slot to slot 0. A write to the sequence word returns the pointer to slot 0.
- R6: A trigger that arrives while a run is in progress is ignored.
- R7: The data word holds the sample right-aligned. Only the low 12, 10, 8 or 6 bits are kept for resolution codes 0 to 3, and the upper bits read zero.
- R8: Reading the data word clears the completion flag. A capture while the completion flag is still set raises overrun, unless the data word is read on that same cycle. Writing 1 to status bit 1 or bit 2 clears that flag.
- R9: The interrupt is high exactly when some flag is set and its enable is set: bit 5 for completion, bit 26 for overrun, bit 6 for window violation.
- R10: When bit 23 is set, a captured value above the high threshold or below the low threshold sets the window flag. Bit 22 has no effect on this check.
- R11: When bit 9 is also set, only captures from the channel in bits 4:0 are compared.
- R12: Bit 12 has no effect on regular sequencing. A scan with it set still converts the full list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (side effect on data word) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| ext_trig | input | 1 | External trigger |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_ch | output | 5 | Channel under conversion |
| conv_sample | input | 12 | Digital result from the converter |
| irq | output | 1 | Combined interrupt |

## Verification
Single conversions are swept over every resolution code and several channels, with samples that differ per run. This separates a wrong cycle count from a wrong alignment mask. Scan runs over list lengths 1 to 4 and discontinuous runs over several subgroup sizes and two list lengths show whether the pointer resumes and wraps correctly, as opposed to restarting or stopping at the list end. Window checks sweep channels whose samples fall above, inside and below the thresholds, and repeat the sweep with the enable and single-channel bits changed. A read timed onto the capture edge separates the read-wins from the overrun-wins ordering.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants, register indices and the control word layout.
// Assumes a 32-bit register port and a converter clock equal to clk.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_SEQ  = 3'd1,
        REG_HTR  = 3'd2,
        REG_LTR  = 3'd3,
        REG_DATA = 3'd4,
        REG_STAT = 3'd5
    } reg_idx_e;

    // Writable bits of the control word; all others are reserved.
    localparam logic [31:0] CTRL_WMASK = 32'h07C0_FFFF;

    typedef struct packed {
        logic [4:0] rsv_hi;
        logic       ovr_ie;
        logic [1:0] res;
        logic       wdg_en;
        logic       wdg_inj_en;
        logic [5:0] rsv_lo;
        logic [2:0] grp_num;
        logic       inj_grp_en;
        logic       grp_en;
        logic       inj_auto;
        logic       wdg_single;
        logic       scan;
        logic       inj_eoc_ie;
        logic       wdg_ie;
        logic       eoc_ie;
        logic [4:0] wdg_ch;
    } ctrl_t;

    // Conversion length in cycles for a resolution code.
    function automatic logic [3:0] conv_cycles(input logic [1:0] res);
        return 4'd15 - {1'b0, res, 1'b0};
    endfunction

endpackage

// File: rtl/adc_cfg_regs.sv
// Module: configuration storage (control, sequence list, thresholds).
// Assumes single-cycle writes; reserved bits never store a value.
module adc_cfg_regs #(
    parameter int SEQ_DEPTH = 4,
    parameter int CH_W      = 5,
    parameter int DATA_W    = 12,
    parameter int ADDR_W    = 3,
    parameter int LEN_W     = (SEQ_DEPTH > 1) ? $clog2(SEQ_DEPTH) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     ctrl_q,
    output logic [31:0]                     seq_q,
    output logic [DATA_W-1:0]               htr_q,
    output logic [DATA_W-1:0]               ltr_q,
    output logic [SEQ_DEPTH-1:0][CH_W-1:0]  slots,
    output logic [LEN_W-1:0]                len_m1,
    output logic                            seq_wr
);
    import adc_seq_pkg::*;

    localparam int          LEN_POS  = 24;
    localparam logic [31:0] SEQ_MASK = ((32'd1 << (SEQ_DEPTH*CH_W)) - 32'd1)
                                     | (((32'd1 << LEN_W) - 32'd1) << LEN_POS);

    assign seq_wr = wr_en && (addr == ADDR_W'(REG_SEQ));

    // Register writes with reserved-bit masking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            seq_q  <= '0;
            htr_q  <= '1;
            ltr_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_W'(REG_CTRL): ctrl_q <= wdata & CTRL_WMASK;
                ADDR_W'(REG_SEQ):  seq_q  <= wdata & SEQ_MASK;
                ADDR_W'(REG_HTR):  htr_q  <= wdata[DATA_W-1:0];
                ADDR_W'(REG_LTR):  ltr_q  <= wdata[DATA_W-1:0];
                default: ;
            endcase
        end
    end

    // Unpack the channel slots from the sequence word.
    for (genvar k = 0; k < SEQ_DEPTH; k++) begin : g_slot
        assign slots[k] = seq_q[k*CH_W +: CH_W];
    end
    assign len_m1 = seq_q[LEN_POS +: LEN_W];

endmodule

// File: rtl/adc_seq_engine.sv
// Module: trigger handling, slot pointer and per-conversion timer.
// Assumes the converter holds its result valid on the capture cycle.
module adc_seq_engine #(
    parameter int SEQ_DEPTH = 4,
    parameter int CH_W      = 5,
    parameter int LEN_W     = (SEQ_DEPTH > 1) ? $clog2(SEQ_DEPTH) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            trig,
    input  logic [1:0]                      res,
    input  logic                            scan,
    input  logic                            grp_en,
    input  logic [2:0]                      grp_num,
    input  logic [LEN_W-1:0]                len_m1,
    input  logic [SEQ_DEPTH-1:0][CH_W-1:0]  slots,
    input  logic                            ptr_clr,
    output logic                            conv_start,
    output logic [CH_W-1:0]                 conv_ch,
    output logic                            cap_valid
);
    import adc_seq_pkg::*;

    localparam int REM_W = (LEN_W > 3) ? LEN_W : 3;

    logic             busy_q, start_q;
    logic [3:0]       cnt_q;
    logic [REM_W-1:0] rem_q;
    logic [LEN_W-1:0] ptr_q, start_idx;
    logic [CH_W-1:0]  ch_q;

    function automatic logic [LEN_W-1:0] nxt(input logic [LEN_W-1:0] i,
                                             input logic [LEN_W-1:0] last);
        return (i == last) ? '0 : i + 1'b1;
    endfunction

    assign start_idx  = grp_en ? ptr_q : '0;
    assign cap_valid  = busy_q && (cnt_q == '0);
    assign conv_start = start_q;
    assign conv_ch    = ch_q;

    // Run control: launch on trigger, count down, chain or finish on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            cnt_q   <= '0;
            rem_q   <= '0;
            ptr_q   <= '0;
            ch_q    <= '0;
        end else begin
            start_q <= 1'b0;
            if (!busy_q) begin
                if (trig) begin
                    ch_q    <= slots[start_idx];
                    ptr_q   <= nxt(start_idx, len_m1);
                    rem_q   <= grp_en ? REM_W'(grp_num) : (scan ? REM_W'(len_m1) : '0);
                    cnt_q   <= conv_cycles(res) - 4'd1;
                    start_q <= 1'b1;
                    busy_q  <= 1'b1;
                end
            end else if (cnt_q == '0) begin
                if (rem_q == '0) begin
                    busy_q <= 1'b0;
                    if (!grp_en) ptr_q <= '0;
                end else begin
                    rem_q   <= rem_q - 1'b1;
                    ch_q    <= slots[ptr_q];
                    ptr_q   <= nxt(ptr_q, len_m1);
                    cnt_q   <= conv_cycles(res) - 4'd1;
                    start_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (ptr_clr) ptr_q <= '0;
        end
    end

    assert_start_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_ptr_in_list_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= len_m1);
    assert_chain_or_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> (!busy_q || conv_start));

endmodule

// File: rtl/adc_result_unit.sv
// Module: result capture, alignment mask, window compare and status flags.
// Assumes samples arrive right-aligned from the converter.
module adc_result_unit #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [CH_W-1:0]   cap_ch,
    input  logic [DATA_W-1:0] sample,
    input  logic [1:0]        res,
    input  logic              wdg_en,
    input  logic              wdg_single,
    input  logic [CH_W-1:0]   wdg_ch,
    input  logic [DATA_W-1:0] htr,
    input  logic [DATA_W-1:0] ltr,
    input  logic              data_rd,
    input  logic              ovr_clr,
    input  logic              wdg_clr,
    output logic [DATA_W-1:0] data_q,
    output logic              eoc_q,
    output logic              ovr_q,
    output logic              wdg_q
);
    logic [DATA_W-1:0] res_mask, masked;
    logic              wdg_hit;

    assign res_mask = {DATA_W{1'b1}} >> {res, 1'b0};
    assign masked   = sample & res_mask;
    assign wdg_hit  = wdg_en && (!wdg_single || (cap_ch == wdg_ch))
                   && ((masked > htr) || (masked < ltr));

    // Data register and flags; a capture takes priority over any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            eoc_q  <= 1'b0;
            ovr_q  <= 1'b0;
            wdg_q  <= 1'b0;
        end else begin
            if (cap_valid) data_q <= masked;
            eoc_q <= cap_valid ? 1'b1 : (data_rd ? 1'b0 : eoc_q);
            if (cap_valid && eoc_q && !data_rd) ovr_q <= 1'b1;
            else if (ovr_clr)                   ovr_q <= 1'b0;
            if (cap_valid && wdg_hit)           wdg_q <= 1'b1;
            else if (wdg_clr)                   wdg_q <= 1'b0;
        end
    end

    assert_eoc_after_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> eoc_q);
    assert_ovr_needs_eoc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(eoc_q));
    assert_upper_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> ((data_q & ~$past(res_mask)) == '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
// Module: top of the conversion sequencer; register read mux and interrupt.
// Assumes reads are combinational on reg_addr; reg_rd_en only marks side effects.
module adc_seq_ctrl #(
    parameter int SEQ_DEPTH = 4,
    parameter int CH_W      = 5,
    parameter int DATA_W    = 12,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ext_trig,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_ch,
    input  logic [DATA_W-1:0] conv_sample,
    output logic              irq
);
    import adc_seq_pkg::*;

    localparam int LEN_W = (SEQ_DEPTH > 1) ? $clog2(SEQ_DEPTH) : 1;

    logic [31:0]                    ctrl_q, seq_q;
    ctrl_t                          cfg;
    logic [DATA_W-1:0]              htr_q, ltr_q, data_q;
    logic [SEQ_DEPTH-1:0][CH_W-1:0] slots;
    logic [LEN_W-1:0]               len_m1;
    logic                           seq_wr, cap_valid, eoc, ovr, wdg;
    logic                           data_rd, stat_wr;
    logic                           unused_ctrl;

    assign cfg         = ctrl_t'(ctrl_q);
    assign data_rd     = reg_rd_en && (reg_addr == ADDR_W'(REG_DATA));
    assign stat_wr     = reg_wr_en && (reg_addr == ADDR_W'(REG_STAT));
    assign unused_ctrl = ^{cfg.rsv_hi, cfg.rsv_lo, cfg.wdg_inj_en, cfg.inj_grp_en,
                           cfg.inj_auto, cfg.inj_eoc_ie};

    adc_cfg_regs #(.SEQ_DEPTH(SEQ_DEPTH), .CH_W(CH_W), .DATA_W(DATA_W),
                   .ADDR_W(ADDR_W), .LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .ctrl_q(ctrl_q), .seq_q(seq_q), .htr_q(htr_q),
        .ltr_q(ltr_q), .slots(slots), .len_m1(len_m1), .seq_wr(seq_wr)
    );

    adc_seq_engine #(.SEQ_DEPTH(SEQ_DEPTH), .CH_W(CH_W), .LEN_W(LEN_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .trig(ext_trig), .res(cfg.res),
        .scan(cfg.scan), .grp_en(cfg.grp_en), .grp_num(cfg.grp_num),
        .len_m1(len_m1), .slots(slots), .ptr_clr(seq_wr),
        .conv_start(conv_start), .conv_ch(conv_ch), .cap_valid(cap_valid)
    );

    adc_result_unit #(.DATA_W(DATA_W), .CH_W(CH_W)) res_i (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_ch(conv_ch),
        .sample(conv_sample), .res(cfg.res), .wdg_en(cfg.wdg_en),
        .wdg_single(cfg.wdg_single), .wdg_ch(cfg.wdg_ch), .htr(htr_q),
        .ltr(ltr_q), .data_rd(data_rd), .ovr_clr(stat_wr && reg_wdata[1]),
        .wdg_clr(stat_wr && reg_wdata[2]), .data_q(data_q), .eoc_q(eoc),
        .ovr_q(ovr), .wdg_q(wdg)
    );

    // Read mux for the addressed register word.
    always_comb begin
        case (reg_addr)
            ADDR_W'(REG_CTRL): reg_rdata = ctrl_q;
            ADDR_W'(REG_SEQ):  reg_rdata = seq_q;
            ADDR_W'(REG_HTR):  reg_rdata = 32'(htr_q);
            ADDR_W'(REG_LTR):  reg_rdata = 32'(ltr_q);
            ADDR_W'(REG_DATA): reg_rdata = 32'(data_q);
            ADDR_W'(REG_STAT): reg_rdata = {29'd0, wdg, ovr, eoc};
            default:           reg_rdata = '0;
        endcase
    end

    // Interrupt combine: each flag gated by its own enable.
    always_comb begin
        irq = (eoc && cfg.eoc_ie) || (ovr && cfg.ovr_ie) || (wdg && cfg.wdg_ie);
    end

    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (eoc || ovr || wdg));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_trig = 1'b0;
    logic        conv_start;
    logic [4:0]  conv_ch;
    logic [11:0] conv_sample;
    logic        irq;
    logic [11:0] smp_xor = '0;

    int errors = 0, checks = 0;
    int got[0:15];
    int ngot;

    always #4 clk = ~clk;

    function automatic logic [11:0] smp_of(input logic [4:0] ch, input logic [11:0] x);
        return (12'(ch) * 12'd157 + 12'd41) ^ x;
    endfunction
    assign conv_sample = smp_of(conv_ch, smp_xor);

    adc_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_trig(ext_trig), .conv_start(conv_start), .conv_ch(conv_ch),
        .conv_sample(conv_sample), .irq(irq)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); #1 reg_wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd_en = 1'b1; #1 d = reg_rdata;
        @(posedge clk); #1 reg_rd_en = 1'b0;
    endtask

    task automatic pulse_trig();
        @(negedge clk) ext_trig = 1'b1;
        @(negedge clk) ext_trig = 1'b0;
    endtask

    // Trigger, then record every start pulse over a window of negedges.
    task automatic fire(input int win);
        ngot = 0;
        pulse_trig();
        for (int c = 0; c < win; c++) begin
            if (c > 0) @(negedge clk);
            if (conv_start && ngot < 16) begin got[ngot] = conv_ch; ngot++; end
        end
    endtask

    task automatic clear_flags();
        logic [31:0] d;
        bus_rd(3'd4, d);
        bus_wr(3'd5, 32'h6);
    endtask

    function automatic logic [31:0] seq_word(input int s0, input int s1, input int s2,
                                             input int s3, input int lm1);
        return 32'(s0) | (32'(s1) << 5) | (32'(s2) << 10) | (32'(s3) << 15) | (32'(lm1) << 24);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int slot[0:3];
        slot[0] = 3; slot[1] = 17; slot[2] = 9; slot[3] = 30;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        bus_rd(3'd0, d); chk("R1", "ctrl reset", d, 0);
        bus_rd(3'd5, d); chk("R8", "status reset", d, 0);
        bus_rd(3'd2, d); chk("R10", "high thr reset", d, 32'hFFF);
        chk("R9", "irq reset", irq, 0);
        chk("R3", "start reset", conv_start, 0);

        // R1 reserved bits
        bus_wr(3'd0, 32'hFFFF_FFFF); bus_rd(3'd0, d); chk("R1", "ctrl all ones", d, 32'h07C0_FFFF);
        bus_wr(3'd0, 32'h0); bus_rd(3'd0, d); chk("R1", "ctrl zero", d, 0);

        // R2, R3, R7: single conversions over every resolution and several channels
        for (int r = 0; r < 4; r++) begin
            for (int ci = 0; ci < 4; ci++) begin
                int ch, n, extra, tc;
                ch = (ci == 0) ? 0 : (ci == 1) ? 7 : (ci == 2) ? 19 : 31;
                tc = 15 - 2 * r;
                smp_xor = 12'(r * 12'h5A3 + ci * 12'h111);
                bus_wr(3'd1, 32'(ch));
                bus_wr(3'd0, (32'(r) << 24) | 32'h20);
                pulse_trig();
                chk("R3", "start pulse", conv_start, 1);
                chk("R3", "start channel", conv_ch, ch);
                n = 0; extra = 0;
                do begin
                    @(negedge clk); n++;
                    if (conv_start) extra++;
                end while (!irq && n < 40);
                chk("R2", "conversion cycles", n, tc);
                repeat (20) begin @(negedge clk); if (conv_start) extra++; end
                chk("R3", "single start count", extra, 0);
                bus_rd(3'd4, d);
                chk("R7", "aligned data", d, 32'(smp_of(5'(ch), smp_xor) & (12'hFFF >> (2 * r))));
                bus_rd(3'd5, d); chk("R8", "eoc cleared by read", d, 0);
            end
        end

        // R4, R12: scan over list lengths with stored-only bit 12 set
        smp_xor = 12'h0;
        for (int len = 1; len <= 4; len++) begin
            bus_wr(3'd1, seq_word(slot[0], slot[1], slot[2], slot[3], len - 1));
            bus_wr(3'd0, (32'd3 << 24) | 32'h100 | 32'h1000);
            fire(len * 9 + 6);
            chk("R12", "scan count", ngot, len);
            for (int i = 0; i < len; i++) chk("R4", "scan order", got[i], slot[i]);
            bus_rd(3'd5, d); chk("R8", "scan overrun", d[1], (len > 1) ? 1 : 0);
            bus_rd(3'd4, d); chk("R4", "scan last data", d, 32'(smp_of(5'(slot[len-1]), 12'h0) & 12'h03F));
            bus_wr(3'd5, 32'h6);
            bus_rd(3'd5, d); chk("R8", "flags cleared", d, 0);
        end

        // R5: discontinuous subgroups resume and wrap
        for (int li = 0; li < 2; li++) begin
            for (int ni = 0; ni < 5; ni++) begin
                int len, nn, k;
                len = 3 + li;
                nn = (ni < 3) ? ni : (ni == 3) ? 4 : 7;
                bus_wr(3'd1, seq_word(slot[0], slot[1], slot[2], slot[3], len - 1));
                bus_wr(3'd0, (32'd3 << 24) | 32'h800 | (32'(nn) << 13));
                k = 0;
                for (int t = 0; t < 3; t++) begin
                    fire((nn + 1) * 9 + 6);
                    chk("R5", "subgroup size", ngot, nn + 1);
                    for (int i = 0; i < ngot && i <= nn; i++)
                        chk("R5", "subgroup channel", got[i], slot[(k + i) % len]);
                    k += nn + 1;
                end
                clear_flags();
            end
        end

        // R6: trigger during a run is ignored
        bus_wr(3'd1, 32'(slot[1]));
        bus_wr(3'd0, 32'd3 << 24);
        ngot = 0;
        pulse_trig();
        if (conv_start) ngot++;
        repeat (3) @(negedge clk);
        ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
        repeat (30) begin @(negedge clk); if (conv_start) ngot++; end
        chk("R6", "busy trigger ignored", ngot, 1);
        clear_flags();

        // R8: overrun set, cleared, avoided by reading, and same-edge read
        fire(14); fire(14);
        bus_rd(3'd5, d); chk("R8", "overrun set", d, 3);
        bus_wr(3'd5, 32'h2);
        bus_rd(3'd5, d); chk("R8", "overrun w1c keeps eoc", d, 1);
        bus_rd(3'd4, d);
        fire(14); bus_rd(3'd4, d); fire(14);
        bus_rd(3'd5, d); chk("R8", "no overrun after read", d, 1);
        smp_xor = 12'hA5A;
        pulse_trig();
        repeat (7) @(negedge clk);
        bus_rd(3'd4, d); chk("R8", "same-edge read old data", d, 32'(smp_of(5'(slot[1]), 12'h0) & 12'h03F));
        repeat (3) @(negedge clk);
        bus_rd(3'd5, d); chk("R8", "same-edge read no overrun", d, 1);
        bus_rd(3'd4, d); chk("R8", "same-edge new data", d, 32'(smp_of(5'(slot[1]), 12'hA5A) & 12'h03F));
        smp_xor = 12'h0;

        // R9: interrupt gating
        fire(14); fire(14);
        #1 chk("R9", "no enables", irq, 0);
        bus_wr(3'd0, (32'd3 << 24) | (32'd1 << 26)); #1 chk("R9", "overrun enable", irq, 1);
        bus_wr(3'd0, (32'd3 << 24) | 32'h20); #1 chk("R9", "eoc enable", irq, 1);
        bus_wr(3'd0, (32'd3 << 24) | 32'h40); #1 chk("R9", "wdg enable only", irq, 0);
        clear_flags();
        bus_wr(3'd0, (32'd3 << 24) | 32'h20 | (32'd1 << 26)); #1 chk("R9", "cleared flags", irq, 0);

        // R10, R11: window compare sweep
        bus_wr(3'd2, 32'h900); bus_wr(3'd3, 32'h200);
        for (int mode = 0; mode < 3; mode++) begin
            for (int ch = 0; ch < 32; ch += 3) begin
                logic [11:0] v;
                int exp;
                v = smp_of(5'(ch), 12'h0);
                if (mode == 0) begin
                    bus_wr(3'd0, (32'd1 << 23) | 32'h40);
                    exp = (v > 12'h900 || v < 12'h200) ? 1 : 0;
                end else if (mode == 1) begin
                    bus_wr(3'd0, (32'd1 << 22) | 32'h40);
                    exp = 0;
                end else begin
                    bus_wr(3'd0, (32'd1 << 23) | 32'h200 | 32'h40 | 32'd15);
                    exp = ((ch == 15) && (v > 12'h900 || v < 12'h200)) ? 1 : 0;
                end
                bus_wr(3'd1, 32'(ch));
                fire(20);
                bus_rd(3'd5, d);
                chk((mode == 2) ? "R11" : "R10", "window flag", d[2], exp);
                chk("R9", "wdg irq", irq, exp);
                clear_flags();
            end
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule